// File: doc/BRIEF.md
# Restartable Two-Cycle Memory Move Unit

This block executes a memory-to-memory move that post-increments both its address registers. The move takes two execute cycles. In the first it reads the operand from the address held in the source register and advances that register by four. In the second it stores the operand at the address held in the destination register, advances that register by four and sets the condition codes from the moved value.

A fault can be reported in the second cycle, after the source register has already advanced. To make the instruction restartable, the unit saves copies of the source register, the destination register and the condition codes when the instruction starts. On a fault in either cycle it puts all three back in the same clock edge and raises a one-cycle access-error pulse. The programming model is then exactly as it was before the instruction, and an outside exception handler can run the move again.

The address register file lives inside the unit. It has a load port, honoured only while the unit is idle, and a combinational read port. Decode, exception handling and the restart itself are outside this block.

Top module: `move_restore_unit`

## Requirements
- R1: A start strobe accepted while idle captures the source and destination register indices. In the next cycle the unit issues a read at the address in the source register. If that read completes without error, the source register holds its old value plus 4 after that clock edge.
- R2: In the cycle after a good read, the unit issues a write of the read operand to the address now held in the destination register. If the write completes without error, the destination register advances by 4 and `done` is high for exactly the following cycle.
- R3: A completed move sets the condition code output `ccr` as follows: bit 3 (N) is operand bit 31, bit 2 (Z) is 1 when the operand is zero, and bit 1 (V) and bit 0 (C) are 0.
- R4: An error on the write restores the source register, the destination register and `ccr` to their values from before the start, at that same clock edge. `accErr` is then high for exactly one cycle, and `done` stays low.
- R5: An error on the read restores the source register and leaves the destination register and `ccr` unchanged. No write is issued, and `accErr` pulses for one cycle.
- R6: When the source and destination indices name the same register, a completed move advances it by 8 and writes to the original address plus 4. A faulted move leaves the register at its single original value.
- R7: A start strobe that arrives while a move is in progress is ignored. It starts no second transfer and changes no register.
- R8: After reset, every address register and `ccr` are zero, and `memValid`, `done` and `accErr` are low.
- R9: `done` and `accErr` are never high together, and every write is issued in the cycle directly after a good read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start a move (taken only while idle) |
| srcSel | input | 3 | Index of the source address register |
| dstSel | input | 3 | Index of the destination address register |
| loadEn | input | 1 | Load an address register (taken only while idle) |
| loadSel | input | 3 | Index of the register to load |
| loadData | input | 32 | Value to load |
| rdSel | input | 3 | Index for the register read port |
| rdData | output | 32 | Contents of register `rdSel` |
| ccr | output | 4 | Condition codes {N,Z,V,C} |
| memValid | output | 1 | Operand memory access strobe |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Operand address |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data, valid in the access cycle |
| memErr | input | 1 | Error acknowledge for the current access |
| done | output | 1 | One-cycle pulse after a completed move |
| accErr | output | 1 | One-cycle pulse after a faulted move |

## Verification
Moves are run with a negative operand and with a zero operand, so that each flag of the condition code rule is shown to respond to its own bit. Distinct registers are then run against the same register used as both source and destination. This tells apart a restore that writes back one shared original value from one that writes back a value already incremented. Faults are injected on the read and on the write separately. A read fault shows that no store is attempted. A write fault shows that the source register's committed increment is undone and that memory is left untouched. A second start strobe during a move checks that the unit does not begin a second transfer.

// File: rtl/move_restore_pkg.sv
package move_restore_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic idle;        // no move in progress
    logic capture;     // latch indices and shadow copies
    logic readPhase;   // first execute cycle
    logic writePhase;  // second execute cycle
    logic incSrc;      // good read: bump source, keep operand
    logic commitDst;   // good write: bump destination, set flags
    logic restore;     // fault: roll back from shadows
  } mrCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } mrState_e;

  localparam int CCR_W = 4;
  localparam int CCR_N = 3;
  localparam int CCR_Z = 2;
  localparam int CCR_V = 1;
  localparam int CCR_C = 0;

endpackage

// File: rtl/move_restore_ctrl.sv
module move_restore_ctrl
  import move_restore_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    memErr,
  output mrCtrl_t ctrl,
  output logic    memValid,
  output logic    memWrite,
  output logic    done,
  output logic    accErr
);

  mrState_e state, stateNext;

  always_comb begin
    ctrl            = '0;
    ctrl.idle       = (state == ST_IDLE);
    ctrl.readPhase  = (state == ST_READ);
    ctrl.writePhase = (state == ST_WRITE);
    ctrl.capture    = ctrl.idle && startStb;
    ctrl.incSrc     = ctrl.readPhase && !memErr;
    ctrl.commitDst  = ctrl.writePhase && !memErr;
    ctrl.restore    = (ctrl.readPhase || ctrl.writePhase) && memErr;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startStb) stateNext = ST_READ;
      ST_READ:  stateNext = memErr ? ST_IDLE : ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      accErr <= 1'b0;
    end else begin
      state  <= stateNext;
      done   <= ctrl.commitDst;
      accErr <= ctrl.restore;
    end
  end

  assign memValid = ctrl.readPhase || ctrl.writePhase;
  assign memWrite = ctrl.writePhase;

endmodule

// File: rtl/move_restore_dp.sv
module move_restore_dp
  import move_restore_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STEP     = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mrCtrl_t           ctrl,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [ADDR_W-1:0] loadData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] rdData,
  output logic [CCR_W-1:0]  ccr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] regs [NUM_REGS];
  logic [SEL_W-1:0]  srcIdx, dstIdx;
  logic [ADDR_W-1:0] shadowSrc, shadowDst;
  logic [CCR_W-1:0]  shadowCcr;
  logic [DATA_W-1:0] operand;
  logic [CCR_W-1:0]  newFlags;

  always_comb begin
    newFlags        = '0;
    newFlags[CCR_N] = operand[DATA_W-1];
    newFlags[CCR_Z] = (operand == '0);
    newFlags[CCR_V] = 1'b0;
    newFlags[CCR_C] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      srcIdx    <= '0;
      dstIdx    <= '0;
      shadowSrc <= '0;
      shadowDst <= '0;
      shadowCcr <= '0;
      operand   <= '0;
      ccr       <= '0;
    end else begin
      if (ctrl.idle && loadEn) regs[loadSel] <= loadData;
      if (ctrl.capture) begin
        srcIdx    <= srcSel;
        dstIdx    <= dstSel;
        shadowSrc <= regs[srcSel];
        shadowDst <= regs[dstSel];
        shadowCcr <= ccr;
      end
      if (ctrl.incSrc) begin
        regs[srcIdx] <= regs[srcIdx] + STEP_V;
        operand      <= memRData;
      end
      if (ctrl.commitDst) begin
        regs[dstIdx] <= regs[dstIdx] + STEP_V;
        ccr          <= newFlags;
      end
      if (ctrl.restore) begin
        // same index: both shadows hold the one original value
        regs[srcIdx] <= shadowSrc;
        regs[dstIdx] <= shadowDst;
        ccr          <= shadowCcr;
      end
    end
  end

  assign rdData   = regs[rdSel];
  assign memAddr  = ctrl.writePhase ? regs[dstIdx] : regs[srcIdx];
  assign memWData = operand;

endmodule

// File: rtl/move_restore_unit.sv
module move_restore_unit
  import move_restore_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STEP     = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [ADDR_W-1:0] loadData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] rdData,
  output logic [CCR_W-1:0]  ccr,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  input  logic              memErr,
  output logic              done,
  output logic              accErr
);

  mrCtrl_t ctrl;

  move_restore_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .memErr(memErr),
    .ctrl(ctrl), .memValid(memValid), .memWrite(memWrite),
    .done(done), .accErr(accErr)
  );

  move_restore_dp #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .srcSel(srcSel), .dstSel(dstSel),
    .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .rdSel(rdSel), .rdData(rdData), .ccr(ccr),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData)
  );

endmodule

// File: rtl/move_restore_chk.sv
module move_restore_chk (
  input logic       clk,
  input logic       rstN,
  input logic       memValid,
  input logic       memWrite,
  input logic       memErr,
  input logic       done,
  input logic       accErr,
  input logic [3:0] ccr
);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && accErr));

  a_r9_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> $past(memValid && !memWrite && !memErr));

  a_r5_quiet_after_fault: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> !memValid);

  a_r4_write_fault_flags: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memErr) |=> (accErr && !done));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    accErr |=> !accErr);

  a_r2_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && !memErr) |=> done);

  a_r3_vc_clear: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ccr[1:0] == 2'b00));

endmodule

bind move_restore_unit move_restore_chk u_chk (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memWrite(memWrite),
  .memErr(memErr), .done(done), .accErr(accErr), .ccr(ccr)
);

// File: tb/move_restore_unit_tb_top.sv
`timescale 1ns/100ps
module move_restore_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [2:0]  srcSel = '0, dstSel = '0, loadSel = '0, rdSel = '0;
  logic        loadEn = 1'b0;
  logic [31:0] loadData = '0;
  logic [31:0] rdData;
  logic [3:0]  ccr;
  logic        memValid, memWrite, memErr, done, accErr;
  logic [31:0] memAddr, memWData, memRData;

  logic [31:0] mem [64];
  logic        failRd = 1'b0, failWr = 1'b0;
  int          writeCount = 0;
  int          checks = 0, errors = 0;
  int          gotDone, gotErr;

  always #2.5 clk = ~clk;

  move_restore_unit dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .srcSel(srcSel), .dstSel(dstSel),
    .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .rdSel(rdSel), .rdData(rdData), .ccr(ccr),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memErr(memErr),
    .done(done), .accErr(accErr)
  );

  assign memRData = mem[memAddr[7:2]];
  assign memErr   = memValid && (memWrite ? failWr : failRd);

  always @(posedge clk) begin
    if (memValid && memWrite) begin
      writeCount <= writeCount + 1;
      if (!memErr) mem[memAddr[7:2]] <= memWData;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadReg(input int idx, input logic [31:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadSel = 3'(idx); loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  function automatic logic [31:0] peek(input int idx);
    rdSel = 3'(idx);
    return dut_i.rdData;
  endfunction

  task automatic readReg(input int idx, output logic [31:0] val);
    rdSel = 3'(idx);
    #0.1;
    val = rdData;
  endtask

  task automatic runMove(input int src, input int dst);
    @(negedge clk);
    startStb = 1'b1; srcSel = 3'(src); dstSel = 3'(dst);
    @(negedge clk);
    startStb = 1'b0;
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) gotDone++;
      if (accErr) gotErr++;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R8 done", 32'(done), 0);
    chk("R8 accErr", 32'(accErr), 0);
    chk("R8 memValid", 32'(memValid), 0);
    chk("R8 ccr", 32'(ccr), 0);
    readReg(5, v); chk("R8 reg5", v, 0);
  endtask

  task automatic testNormalNegative();
    logic [31:0] v; int w0;
    loadReg(1, 32'h10); loadReg(2, 32'h80);
    mem[4] = 32'h8000_0005; mem[32] = 32'h0000_DEAD;
    w0 = writeCount;
    runMove(1, 2);
    chk("R2 done pulse", 32'(gotDone), 1);
    chk("R9 no error", 32'(gotErr), 0);
    readReg(1, v); chk("R1 src +4", v, 32'h14);
    readReg(2, v); chk("R2 dst +4", v, 32'h84);
    chk("R2 stored operand", mem[32], 32'h8000_0005);
    chk("R3 ccr negative", 32'(ccr), 32'b1000);
    chk("R9 one write", 32'(writeCount - w0), 1);
  endtask

  task automatic testNormalZero();
    logic [31:0] v;
    loadReg(4, 32'h30); loadReg(5, 32'h90);
    mem[12] = 32'h0; mem[36] = 32'h1111;
    runMove(4, 5);
    chk("R3 ccr zero", 32'(ccr), 32'b0100);
    chk("R2 zero stored", mem[36], 32'h0);
    readReg(4, v); chk("R1 src +4 zero case", v, 32'h34);
    readReg(5, v); chk("R2 dst +4 zero case", v, 32'h94);
  endtask

  task automatic testWriteFault();
    logic [31:0] v;
    mem[5] = 32'h1234; mem[33] = 32'hAAAA;
    failWr = 1'b1;
    runMove(1, 2);
    failWr = 1'b0;
    chk("R4 accErr one cycle", 32'(gotErr), 1);
    chk("R4 no done", 32'(gotDone), 0);
    readReg(1, v); chk("R4 src restored", v, 32'h14);
    readReg(2, v); chk("R4 dst restored", v, 32'h84);
    chk("R4 ccr restored", 32'(ccr), 32'b0100);
    chk("R4 memory untouched", mem[33], 32'hAAAA);
  endtask

  task automatic testReadFault();
    logic [31:0] v; int w0;
    w0 = writeCount;
    failRd = 1'b1;
    runMove(1, 2);
    failRd = 1'b0;
    chk("R5 accErr one cycle", 32'(gotErr), 1);
    chk("R5 no write issued", 32'(writeCount - w0), 0);
    readReg(1, v); chk("R5 src restored", v, 32'h14);
    readReg(2, v); chk("R5 dst unchanged", v, 32'h84);
    chk("R5 ccr unchanged", 32'(ccr), 32'b0100);
  endtask

  task automatic testSameReg();
    logic [31:0] v;
    loadReg(3, 32'h20);
    mem[8] = 32'h7FFF_FFFF; mem[9] = 32'h0;
    runMove(3, 3);
    readReg(3, v); chk("R6 same reg +8", v, 32'h28);
    chk("R6 write at original+4", mem[9], 32'h7FFF_FFFF);
    chk("R3 ccr positive", 32'(ccr), 32'b0000);
    failWr = 1'b1;
    runMove(3, 3);
    failWr = 1'b0;
    readReg(3, v); chk("R6 same reg fault restore", v, 32'h28);
    chk("R6 fault signalled", 32'(gotErr), 1);
  endtask

  task automatic testBusyStart();
    logic [31:0] v; int w0;
    loadReg(6, 32'h40); loadReg(7, 32'hA0); loadReg(0, 32'h0);
    mem[16] = 32'h55;
    w0 = writeCount;
    @(negedge clk);
    startStb = 1'b1; srcSel = 3'd6; dstSel = 3'd7;
    @(negedge clk);
    srcSel = 3'd0; dstSel = 3'd0;
    @(negedge clk);
    startStb = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 single write", 32'(writeCount - w0), 1);
    readReg(0, v); chk("R7 reg0 untouched", v, 32'h0);
    readReg(6, v); chk("R7 src of first move", v, 32'h44);
    readReg(7, v); chk("R7 dst of first move", v, 32'hA4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormalNegative();
    testNormalZero();
    testWriteFault();
    testReadFault();
    testSameReg();
    testBusyStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule